// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a load/store unit and a byte-addressed, big-endian data bus that carries only naturally aligned transfers. It takes one operand request at a time: address, size (byte, word or long), direction and write data. If the operand is aligned, it sends one bus transfer. If not, it breaks the operand into a fixed series of smaller aligned transfers in ascending address order, with the most significant bytes first. Each transfer uses a valid/ready handshake.

Write data is placed on the byte lanes that match each piece's address, and all other lanes are driven to zero. For reads, the returned pieces are shifted into an accumulator. A single-cycle completion pulse then presents the zero-extended operand. The pulse also reports the extra bus cycles and extra transfers that the split cost.

Top module: `mis_split`

## Requirements
- R1: Size encoding is 0 = byte, 1 = word, 2 = long. A byte request, a word request at an even address and a long request at an address whose bits [1:0] are 00 each produce exactly one bus transfer at the request address and size, reported with 0 extra cycles and 0 extra transfers.
- R2: A word request at an odd address A produces two byte transfers, first at A (operand bits 15:8) and then at A+1 (bits 7:0).
- R3: A long request at an odd address A produces a byte at A (bits 31:24), then a word at A+1 (bits 23:8), then a byte at A+3 (bits 7:0).
- R4: A long request whose address bits [1:0] are 10 produces a word at A (bits 31:16) and then a word at A+2 (bits 15:0).
- R5: Every bus transfer is naturally aligned: a word transfer has address bit 0 clear, and a long transfer has address bits [1:0] clear.
- R6: Write data uses big-endian lanes. The byte at address offset k within a 32-bit word uses bus_wdata bits [31-8k : 24-8k]. A piece's bytes occupy the lanes of its addresses, with its most significant byte at its lowest address. Lanes outside the piece are zero.
- R7: For a read, rdata during the done pulse equals the bytes at A, A+1, … (as many as the operand size) concatenated most significant first and zero-extended to 32 bits. Each byte is taken from the bus_rdata lane of its address in the cycle its transfer is accepted.
- R8: done is high for exactly one cycle, and it is the cycle right after the last transfer of a request is accepted.
- R9: During done, extra_cyc and extra_xfer report the cost of the split. A misaligned word costs 2 cycles/1 transfer for a read and 1/1 for a write. A long at an odd address costs 3/2 for a read and 2/2 for a write. A long at offset 10 costs 2/1 for a read and 1/1 for a write.
- R10: req_ready is low from the cycle after a request is accepted until done. A request offered during that time is not taken, and req_ready is high again in the done cycle.
- R11: bus_valid rises in the cycle after a request is accepted. While bus_valid is high and bus_ready is low, bus_addr, bus_size, bus_write and bus_wdata hold their values.
- R12: Under reset, req_ready is high, and bus_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request offered |
| req_ready | output | 1 | Splitter can accept a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store operand, right-justified |
| bus_valid | output | 1 | Aligned transfer presented |
| bus_ready | input | 1 | Bus accepts the transfer this cycle |
| bus_addr | output | ADDR_W | Transfer byte address |
| bus_size | output | 2 | Transfer size, same encoding as req_size |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | DATA_W | Store data on big-endian byte lanes |
| bus_rdata | input | DATA_W | Load data on big-endian byte lanes, valid when the transfer is accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Assembled load operand, zero-extended |
| extra_cyc | output | 2 | Extra bus cycles caused by the split |
| extra_xfer | output | 2 | Extra transfers caused by the split |

## Verification
The hardest situation to create from the ports is a stall on the middle word of a long split at an odd address. In that case the lane data and the write shift state must hold across idle cycles, while the read accumulator has already absorbed the first byte. The bench first runs every size, offset and direction with the bus always ready. It then runs long random streams in which bus_ready drops on about a quarter of cycles, so stalls fall on every piece position, including addresses near the top of the address space where the pieces wrap.

// File: rtl/mis_split_pkg.sv
package mis_split_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } sz_e;

   typedef enum logic [1:0] {
      SP_NONE   = 2'd0,
      SP_W_ODD  = 2'd1,
      SP_L_ODD  = 2'd2,
      SP_L_HALF = 2'd3
   } split_e;

   function automatic int bits_of(sz_e s);
      case (s)
         SZ_BYTE: return 8;
         SZ_WORD: return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/mis_split_plan.sv
module mis_split_plan
   import mis_split_pkg::*;
(
   input  logic [1:0] size_in,
   input  logic [1:0] lo,
   input  logic       write,
   output sz_e        size_n,
   output split_e     kind,
   output logic [1:0] last_idx,
   output logic [1:0] extra_cyc
);

   always_comb begin
      case (size_in)
         2'd0:    size_n = SZ_BYTE;
         2'd1:    size_n = SZ_WORD;
         default: size_n = SZ_LONG;
      endcase
   end

   always_comb begin
      kind = SP_NONE;
      if (size_n == SZ_WORD && lo[0])
         kind = SP_W_ODD;
      else if (size_n == SZ_LONG && lo[0])
         kind = SP_L_ODD;
      else if (size_n == SZ_LONG && lo[1])
         kind = SP_L_HALF;
   end

   always_comb begin
      case (kind)
         SP_W_ODD:  begin last_idx = 2'd1; extra_cyc = write ? 2'd1 : 2'd2; end
         SP_L_ODD:  begin last_idx = 2'd2; extra_cyc = write ? 2'd2 : 2'd3; end
         SP_L_HALF: begin last_idx = 2'd1; extra_cyc = write ? 2'd1 : 2'd2; end
         default:   begin last_idx = 2'd0; extra_cyc = 2'd0; end
      endcase
   end

endmodule

// File: rtl/mis_split_piece.sv
module mis_split_piece
   import mis_split_pkg::*;
(
   input  split_e     kind,
   input  sz_e        op_size,
   input  logic [1:0] idx,
   output sz_e        psize,
   output logic [1:0] poff
);

   always_comb begin
      psize = op_size;
      poff  = 2'd0;
      case (kind)
         SP_W_ODD: begin
            psize = SZ_BYTE;
            poff  = {1'b0, idx[0]};
         end
         SP_L_ODD: begin
            case (idx)
               2'd0:    begin psize = SZ_BYTE; poff = 2'd0; end
               2'd1:    begin psize = SZ_WORD; poff = 2'd1; end
               default: begin psize = SZ_BYTE; poff = 2'd3; end
            endcase
         end
         SP_L_HALF: begin
            psize = SZ_WORD;
            poff  = idx[0] ? 2'd2 : 2'd0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mis_split_lanes.sv
module mis_split_lanes
   import mis_split_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  sz_e               psize,
   input  logic [$clog2(DATA_W/8)-1:0] lane_lo,
   input  logic [DATA_W-1:0] pval,
   output logic [DATA_W-1:0] lane_wdata,
   input  logic [DATA_W-1:0] lane_rdata,
   output logic [DATA_W-1:0] rpiece
);

   localparam int NBYTES = DATA_W / 8;
   localparam int LANE_W = $clog2(NBYTES);

   logic [LANE_W:0] nb;
   assign nb = (LANE_W + 1)'(1) << psize;

   for (genvar l = 0; l < NBYTES; l++) begin : g_wlane
      int              rel;
      logic            act;
      logic [LANE_W-1:0] k;
      assign rel = int'(lane_lo) + int'(nb) - 1 - l;
      assign act = (l >= int'(lane_lo)) && (l < int'(lane_lo) + int'(nb));
      assign k   = LANE_W'(rel);
      assign lane_wdata[DATA_W-1-8*l -: 8] = act ? pval[8*k +: 8] : 8'h00;
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_rbyte
      int              src;
      logic [LANE_W-1:0] j;
      assign src = int'(lane_lo) + int'(nb) - 1 - b;
      assign j   = LANE_W'(src);
      assign rpiece[8*b +: 8] = (b < int'(nb)) ? lane_rdata[DATA_W-1-8*j -: 8] : 8'h00;
   end

endmodule

// File: rtl/mis_split.sv
module mis_split
   import mis_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        extra_cyc,
   output logic [1:0]        extra_xfer
);

   localparam int NBYTES = DATA_W / 8;
   localparam int LANE_W = $clog2(NBYTES);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("mis_split: DATA_W must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("mis_split: ADDR_W must be at least 3");
   end

   logic              busy;
   logic [ADDR_W-1:0] base_q;
   sz_e               size_q;
   logic              wr_q;
   split_e            kind_q;
   logic [1:0]        last_q;
   logic [1:0]        idx_q;
   logic [DATA_W-1:0] wsh_q;
   logic [DATA_W-1:0] acc_q;
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;
   logic [1:0]        ecyc_q;
   logic [1:0]        exfer_q;

   sz_e        plan_size;
   split_e     plan_kind;
   logic [1:0] plan_last;
   logic [1:0] plan_ecyc;

   mis_split_plan u_plan (
      .size_in   (req_size),
      .lo        (req_addr[1:0]),
      .write     (req_write),
      .size_n    (plan_size),
      .kind      (plan_kind),
      .last_idx  (plan_last),
      .extra_cyc (plan_ecyc)
   );

   sz_e        psize;
   logic [1:0] poff;

   mis_split_piece u_piece (
      .kind    (kind_q),
      .op_size (size_q),
      .idx     (idx_q),
      .psize   (psize),
      .poff    (poff)
   );

   logic [ADDR_W-1:0] paddr;
   int                pbits;
   logic [DATA_W-1:0] pval;
   logic [DATA_W-1:0] lane_wd;
   logic [DATA_W-1:0] rpiece;
   logic [DATA_W-1:0] acc_next;

   assign paddr = base_q + ADDR_W'(poff);
   assign pbits = bits_of(psize);
   assign pval  = wsh_q >> (DATA_W - pbits);

   mis_split_lanes #(.DATA_W(DATA_W)) u_lanes (
      .psize      (psize),
      .lane_lo    (paddr[LANE_W-1:0]),
      .pval       (pval),
      .lane_wdata (lane_wd),
      .lane_rdata (bus_rdata),
      .rpiece     (rpiece)
   );

   logic accept;
   logic xfer;
   logic last_piece;

   assign req_ready  = !busy;
   assign accept     = req_valid && req_ready;
   assign xfer       = busy && bus_ready;
   assign last_piece = (idx_q == last_q);
   assign acc_next   = (pbits >= DATA_W) ? rpiece : ((acc_q << pbits) | rpiece);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         base_q  <= '0;
         size_q  <= SZ_BYTE;
         wr_q    <= 1'b0;
         kind_q  <= SP_NONE;
         last_q  <= 2'd0;
         idx_q   <= 2'd0;
         wsh_q   <= '0;
         acc_q   <= '0;
         done_q  <= 1'b0;
         rdata_q <= '0;
         ecyc_q  <= 2'd0;
         exfer_q <= 2'd0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            base_q  <= req_addr;
            size_q  <= plan_size;
            wr_q    <= req_write;
            kind_q  <= plan_kind;
            last_q  <= plan_last;
            idx_q   <= 2'd0;
            acc_q   <= '0;
            wsh_q   <= req_wdata << (DATA_W - bits_of(plan_size));
            ecyc_q  <= plan_ecyc;
            exfer_q <= plan_last;
         end else if (xfer) begin
            wsh_q <= (pbits >= DATA_W) ? '0 : (wsh_q << pbits);
            acc_q <= acc_next;
            idx_q <= idx_q + 2'd1;
            if (last_piece) begin
               busy    <= 1'b0;
               done_q  <= 1'b1;
               rdata_q <= wr_q ? '0 : acc_next;
            end
         end
      end
   end

   assign bus_valid  = busy;
   assign bus_addr   = paddr;
   assign bus_size   = psize;
   assign bus_write  = wr_q;
   assign bus_wdata  = wr_q ? lane_wd : '0;
   assign done       = done_q;
   assign rdata      = rdata_q;
   assign extra_cyc  = ecyc_q;
   assign extra_xfer = exfer_q;

   AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> bus_valid); // R11
   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_write) && $stable(bus_wdata)); // R11
   AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> (bus_size != 2'd2 || bus_addr[1:0] == 2'b00) && (bus_size != 2'd1 || !bus_addr[0])); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
   AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(bus_valid && bus_ready)); // R8
   AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> !req_ready); // R10

endmodule

// File: tb/mis_split_tb_top.sv
`timescale 1ns/1ps
module mis_split_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic        bus_write;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        done;
   logic [31:0] rdata;
   logic [1:0]  extra_cyc;
   logic [1:0]  extra_xfer;

   always #2 clk = ~clk;

   mis_split dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done(done), .rdata(rdata),
      .extra_cyc(extra_cyc), .extra_xfer(extra_xfer)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int last_hs_cyc = -10;
   bit stall_en = 1'b0;

   logic [31:0] lg_addr [4];
   logic [1:0]  lg_size [4];
   logic [31:0] lg_wd   [4];
   int          n_log = 0;

   bit          pend = 1'b0;
   logic [31:0] pend_addr, pend_wd;
   logic [1:0]  pend_size;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(logic [31:0] a);
      return 8'(a * 32'd29) ^ 8'(a >> 5) ^ 8'h5A;
   endfunction

   function automatic int exp_n(logic [1:0] s, logic [31:0] a);
      if (s == 2'd1 && a[0]) return 2;
      if (s == 2'd2 && a[0]) return 3;
      if (s == 2'd2 && a[1]) return 2;
      return 1;
   endfunction

   function automatic int exp_off(logic [1:0] s, logic [31:0] a, int i);
      if (s == 2'd2 && a[0]) return (i == 0) ? 0 : (i == 1) ? 1 : 3;
      if (s == 2'd2 && a[1]) return 2 * i;
      return i;
   endfunction

   function automatic logic [1:0] exp_sz(logic [1:0] s, logic [31:0] a, int i);
      if (s == 2'd1 && a[0]) return 2'd0;
      if (s == 2'd2 && a[0]) return (i == 1) ? 2'd1 : 2'd0;
      if (s == 2'd2 && a[1]) return 2'd1;
      return s;
   endfunction

   function automatic logic [1:0] exp_ecyc(logic [1:0] s, logic [31:0] a, bit w);
      if (s == 2'd1 && a[0]) return w ? 2'd1 : 2'd2;
      if (s == 2'd2 && a[0]) return w ? 2'd2 : 2'd3;
      if (s == 2'd2 && a[1]) return w ? 2'd1 : 2'd2;
      return 2'd0;
   endfunction

   function automatic string req_of(logic [1:0] s, logic [31:0] a);
      if (s == 2'd1 && a[0]) return "R2";
      if (s == 2'd2 && a[0]) return "R3";
      if (s == 2'd2 && a[1]) return "R4";
      return "R1";
   endfunction

   // bus responder and monitor
   always @(negedge clk) begin
      if (rst_n) begin
         bit rdy;
         if (pend)
            chk(bus_valid && bus_addr == pend_addr && bus_size == pend_size && bus_wdata == pend_wd,
                "R11", "stalled transfer changed", bus_addr, pend_addr);
         pend = 1'b0;
         rdy = stall_en ? ($urandom % 4 != 0) : 1'b1;
         bus_ready = rdy;
         for (int l = 0; l < 4; l++)
            bus_rdata[31-8*l -: 8] = mbyte({bus_addr[31:2], 2'(l)});
         if (bus_valid) begin
            chk((bus_size != 2'd2 || bus_addr[1:0] == 2'b00) && (bus_size != 2'd1 || !bus_addr[0]),
                "R5", "misaligned bus transfer", bus_addr, {bus_addr[31:2], 2'b00});
            if (rdy) begin
               if (n_log < 4) begin
                  lg_addr[n_log] = bus_addr;
                  lg_size[n_log] = bus_size;
                  lg_wd[n_log]   = bus_wdata;
               end
               n_log++;
               last_hs_cyc = cyc;
            end else begin
               pend = 1'b1;
               pend_addr = bus_addr;
               pend_size = bus_size;
               pend_wd = bus_wdata;
            end
         end
      end
   end

   task automatic run_op(logic [31:0] a, logic [1:0] s, bit w, logic [31:0] d);
      int nb, ne, t;
      logic [31:0] op, exp_rd;
      string rq;
      nb = 1 << s;
      op = (s == 2'd2) ? d : (s == 2'd1) ? {16'h0, d[15:0]} : {24'h0, d[7:0]};
      ne = exp_n(s, a);
      rq = req_of(s, a);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 32'd1);
      n_log = 0;
      req_addr = a; req_size = s; req_write = w; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      chk(bus_valid == 1'b1, "R11", "bus_valid after accept", 32'(bus_valid), 32'd1);
      req_addr = ~a; req_wdata = ~d; req_write = ~w;
      t = 0;
      while (!done && t < 60) begin
         chk(req_ready == 1'b0, "R10", "ready while busy", 32'(req_ready), 32'd0);
         @(negedge clk);
         t++;
      end
      req_valid = 1'b0;
      chk(done == 1'b1, "R8", "done never seen", 32'(done), 32'd1);
      chk(cyc == last_hs_cyc + 1, "R8", "done timing", 32'(cyc), 32'(last_hs_cyc + 1));
      chk(req_ready == 1'b1, "R10", "ready in done cycle", 32'(req_ready), 32'd1);
      chk(n_log == ne, rq, "transfer count", 32'(n_log), 32'(ne));
      for (int i = 0; i < ne && i < n_log && i < 4; i++) begin
         logic [31:0] ea;
         ea = a + 32'(exp_off(s, a, i));
         chk(lg_addr[i] == ea && lg_size[i] == exp_sz(s, a, i), rq, "piece address/size",
             lg_addr[i], ea);
         if (w) begin
            logic [31:0] ew;
            int pn;
            ew = '0;
            pn = 1 << lg_size[i];
            for (int l = 0; l < 4; l++) begin
               if (l >= int'(lg_addr[i][1:0]) && l < int'(lg_addr[i][1:0]) + pn) begin
                  int bi;
                  bi = int'({lg_addr[i][31:2], 2'(l)} - a);
                  ew[31-8*l -: 8] = 8'(op >> (8 * (nb - 1 - bi)));
               end
            end
            chk(lg_wd[i] == ew, "R6", "write lanes", lg_wd[i], ew);
         end
      end
      if (!w) begin
         exp_rd = '0;
         for (int i = 0; i < nb; i++) exp_rd = (exp_rd << 8) | 32'(mbyte(a + 32'(i)));
         chk(rdata == exp_rd, "R7", "read operand", rdata, exp_rd);
      end
      chk(extra_cyc == exp_ecyc(s, a, w), "R9", "extra cycles", 32'(extra_cyc), 32'(exp_ecyc(s, a, w)));
      chk(extra_xfer == 2'(ne - 1), "R9", "extra transfers", 32'(extra_xfer), 32'(ne - 1));
      @(negedge clk);
      chk(done == 1'b0, "R8", "done lasted more than one cycle", 32'(done), 32'd0);
   endtask

   task automatic report;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      report();
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_1234);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R12", "reset state",
          {29'd0, req_ready, bus_valid, done}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R12", "after reset",
          {29'd0, req_ready, bus_valid, done}, 32'h4);
      // directed: every size, offset and direction, bus never stalls
      for (int s = 0; s < 3; s++)
         for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++)
               run_op(32'h0000_1000 + 32'(o), 2'(s), w[0], 32'hA1B2_C3D4);
      // wrap at the top of the address space
      run_op(32'hFFFF_FFFD, 2'd2, 1'b0, 32'h0);
      run_op(32'hFFFF_FFFF, 2'd2, 1'b1, 32'h1122_3344);
      run_op(32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0);
      // random with stalls
      stall_en = 1'b1;
      for (int n = 0; n < 600; n++)
         run_op($urandom, 2'($urandom % 3), 1'($urandom), $urandom);
      report();
      $finish;
   end

endmodule